// File: doc/BRIEF.md
# Block Floating Point Pass Sequencer

This block keeps track of the shared exponent of an FFT whose butterflies run in block floating point. The butterfly datapath starts one operation per cycle. Each result carries a 2-bit weighting tag that records how far that word's binary point sits from the pass-wide reference. The sequencer watches two control strobes from the FFT controller. The first is an active-low start-of-transform pulse. The second is a run signal that stays high while a pass is fed and drops low for the pipeline flush. Over each pass the block gathers the smallest tag among the butterfly results. Once the last result of the pass has arrived, it moves the global weighting register by that tag's offset, so the four binary-point positions the next pass can use follow the size of the data.

The register is a 5-bit two's-complement count of binary-point movement, where positive means the point has moved to the right. The block also presents a 6-bit form of it and a probe port. The probe port combines the register with any word tag to give that word's total binary-point movement, which output normalisation needs. During the first pass of a transform the block raises a flag that tells the butterfly to disregard its input tags.

Top module: `bfp_pass_seq`

## Requirements
- R1: After reset, `gwr` is 0, `gwr_wide` is 0 and `tag_ignore` is 1.
- R2: A cycle with `sof_n` low makes `gwr` read 0 from the next cycle onward, whatever its earlier value.
- R3: `tag_ignore` is 1 in the cycle where `sof_n` is low and stays 1 until the first pass has been committed. It is 0 from the cycle after that commit until the next start strobe.
- R4: Let t0 be the cycle in which `pass_run` first goes low. `gwr` is committed at the clock edge that ends cycle t0+DRAIN-1 (DRAIN = 5) and shows the new value from cycle t0+DRAIN. `gwr` changes at no other edge, except on a start strobe.
- R5: A butterfly result for the input presented in cycle t shows up on `res_vld`/`res_tag` in cycle t+DRAIN-1. At commit, `gwr` gains the offset of the smallest `res_tag` seen with `res_vld` high during the pass, where tag 00 = -1, 01 = 0, 10 = +1 and 11 = +2.
- R6: A `res_tag` value presented while `res_vld` is low has no effect on the update.
- R7: If `pass_run` stays low for longer than DRAIN cycles, only one commit happens, and `gwr` holds steady until the next pass.
- R8: The signed value of the register is clamped to the range -8 to +23. An update that would leave this range stops at the bound instead.
- R9: `gwr_wide` is `gwr` with a sign bit added on top, and that bit is the AND of `gwr[4]` and `gwr[3]`. Codes 10000 to 10111 therefore read as +16 to +23, and codes 11000 to 11111 read as -8 to -1.
- R10: `probe_move` is the signed value of `gwr_wide` plus the offset of `probe_tag` (00 = -1, 01 = 0, 10 = +1, 11 = +2), as a 7-bit two's-complement number, for example 9 with tag 10 gives 10.
- R11: A pass in which `res_vld` never goes high leaves `gwr` unchanged at its commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sof_n | input | 1 | Start-of-transform strobe, low for the first input cycle only |
| pass_run | input | 1 | High while a pass is fed; low from the last input cycle through the flush |
| res_vld | input | 1 | Butterfly result tag is valid this cycle |
| res_tag | input | 2 | Weighting tag of the current butterfly result |
| probe_tag | input | 2 | Word tag to convert into a total binary-point movement |
| gwr | output | 5 | Global weighting register, two's complement |
| gwr_wide | output | 6 | Sign-extended 6-bit form of the register |
| tag_ignore | output | 1 | First pass of a transform: butterfly input tags must be ignored |
| probe_move | output | 7 | Total binary-point movement for `probe_tag`, two's complement |

## Verification
The assertions assume that the controller keeps `pass_run` low for at least DRAIN cycles between passes. They also assume that `res_vld` is only raised for results that belong to the current pass, which means every result has landed by the commit cycle. This matters because the register should move by no more than one tag offset per pass and only at a flush or a start strobe. The stimulus builds each pass from a fixed result latency of DRAIN-1 cycles, and its low windows are never shorter than DRAIN cycles. Start strobes come only on a pass's first input cycle, with `pass_run` held high before the first transform.

// File: rtl/bfp_seq_pkg.sv
package bfp_seq_pkg;

    localparam int GW_BITS   = 5;
    localparam int WIDE_BITS = GW_BITS + 1;
    localparam int MOVE_BITS = WIDE_BITS + 1;
    localparam int W_FLOOR   = -8;
    localparam int W_CEIL    = 23;

    typedef logic [1:0]                  wtag_t;
    typedef logic [GW_BITS-1:0]          gwr_t;
    typedef logic signed [WIDE_BITS-1:0] wide_t;
    typedef logic signed [MOVE_BITS-1:0] move_t;
    typedef logic signed [2:0]           offs_t;

    typedef struct packed {
        logic  vld;
        wtag_t tag;
    } growth_t;

    localparam wtag_t TAG_MAX = 2'b11;

    // Tag to binary-point offset: 00 -> -1, 01 -> 0, 10 -> +1, 11 -> +2
    function automatic offs_t tag_offset(wtag_t t);
        return $signed({1'b0, t}) - 3'sd1;
    endfunction

    // Extended form: new sign is the AND of the two top bits
    function automatic wide_t widen(gwr_t g);
        return {g[GW_BITS-1] & g[GW_BITS-2], g};
    endfunction

    function automatic wide_t clamp_step(wide_t cur, offs_t d);
        logic signed [7:0] s;
        s = {{(8-WIDE_BITS){cur[WIDE_BITS-1]}}, cur} + {{5{d[2]}}, d};
        if (s < 8'(W_FLOOR))
            return wide_t'(W_FLOOR);
        else if (s > 8'(W_CEIL))
            return wide_t'(W_CEIL);
        else
            return s[WIDE_BITS-1:0];
    endfunction

    function automatic move_t exp_move(wide_t w, wtag_t t);
        offs_t o;
        o = tag_offset(t);
        return {w[WIDE_BITS-1], w} + {{(MOVE_BITS-3){o[2]}}, o};
    endfunction

endpackage

// File: rtl/bfp_flush_timer.sv
module bfp_flush_timer #(
    parameter int DRAIN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic pass_run,
    output logic commit
);
    localparam int CW = $clog2(DRAIN + 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            low_cnt <= '0;
        else if (pass_run)
            low_cnt <= '0;
        else if (low_cnt != CW'(DRAIN))
            low_cnt <= low_cnt + 1'b1;
    end

    // Final flush cycle: last result of the pass is on the result port
    assign commit = !pass_run && (low_cnt == CW'(DRAIN - 1));

endmodule

// File: rtl/bfp_growth_min.sv
module bfp_growth_min
    import bfp_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  logic    commit,
    input  growth_t res,
    output logic    seen,
    output wtag_t   min_tag
);
    wtag_t min_q;
    logic  seen_q;

    always_comb begin
        min_tag = min_q;
        if (res.vld && (res.tag < min_q))
            min_tag = res.tag;
        seen = seen_q | res.vld;
    end

    always_ff @(posedge clk) begin
        if (rst || clear || commit) begin
            min_q  <= TAG_MAX;
            seen_q <= 1'b0;
        end else begin
            min_q  <= min_tag;
            seen_q <= seen;
        end
    end

endmodule

// File: rtl/bfp_weight_reg.sv
module bfp_weight_reg
    import bfp_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  commit,
    input  logic  seen,
    input  wtag_t min_tag,
    output wide_t w_q,
    output logic  first_q
);
    always_ff @(posedge clk) begin
        if (rst || start) begin
            w_q     <= '0;
            first_q <= 1'b1;
        end else if (commit) begin
            first_q <= 1'b0;
            if (seen)
                w_q <= clamp_step(w_q, tag_offset(min_tag));
        end
    end

endmodule

// File: rtl/bfp_pass_seq.sv
module bfp_pass_seq
    import bfp_seq_pkg::*;
#(
    parameter int DRAIN = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sof_n,
    input  logic       pass_run,
    input  logic       res_vld,
    input  logic [1:0] res_tag,
    input  logic [1:0] probe_tag,
    output logic [4:0] gwr,
    output logic [5:0] gwr_wide,
    output logic       tag_ignore,
    output logic [6:0] probe_move
);
    logic    commit;
    logic    seen;
    wtag_t   min_tag;
    wide_t   w_q;
    logic    first_q;
    growth_t res;

    assign res = '{vld: res_vld, tag: res_tag};

    bfp_flush_timer #(.DRAIN(DRAIN)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .pass_run (pass_run),
        .commit   (commit)
    );

    bfp_growth_min u_min (
        .clk     (clk),
        .rst     (rst),
        .clear   (!sof_n),
        .commit  (commit),
        .res     (res),
        .seen    (seen),
        .min_tag (min_tag)
    );

    bfp_weight_reg u_wreg (
        .clk     (clk),
        .rst     (rst),
        .start   (!sof_n),
        .commit  (commit),
        .seen    (seen),
        .min_tag (min_tag),
        .w_q     (w_q),
        .first_q (first_q)
    );

    assign gwr        = w_q[GW_BITS-1:0];
    assign gwr_wide   = widen(gwr);
    assign tag_ignore = !sof_n || first_q;
    assign probe_move = exp_move(widen(gwr), probe_tag);

endmodule

// File: rtl/bfp_pass_seq_chk.sv
module bfp_pass_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       sof_n,
    input logic       pass_run,
    input logic [4:0] gwr,
    input logic [5:0] gwr_wide,
    input logic       tag_ignore
);
    // R2: a start strobe clears the register on the next cycle
    p_clear_on_start_r2: assert property (@(posedge clk) disable iff (rst)
        !sof_n |=> (gwr == 5'd0));

    // R3: the ignore flag is up whenever the start strobe is low
    p_ignore_at_start_r3: assert property (@(posedge clk) disable iff (rst)
        !sof_n |-> tag_ignore);

    // R3: the ignore flag drops only during a flush
    p_ignore_drop_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(tag_ignore) |-> $past(!pass_run));

    // R4: register moves only after a flush cycle or a start strobe
    p_hold_in_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (gwr != $past(gwr)) |-> ($past(!sof_n) || $past(!pass_run)));

    // R5: one commit moves the register by at most one tag offset
    p_step_bound_r5: assert property (@(posedge clk) disable iff (rst)
        ((gwr != $past(gwr)) && $past(sof_n)) |->
        (($signed(gwr_wide) - $signed($past(gwr_wide)) >= -1) &&
         ($signed(gwr_wide) - $signed($past(gwr_wide)) <= 2)));

endmodule

bind bfp_pass_seq bfp_pass_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sof_n      (sof_n),
    .pass_run   (pass_run),
    .gwr        (gwr),
    .gwr_wide   (gwr_wide),
    .tag_ignore (tag_ignore)
);

// File: tb/sim_bfp_pass_seq.sv
`timescale 1ns/1ps
module sim_bfp_pass_seq;

    localparam int DRAIN = 5;
    localparam int NB    = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sof_n = 1'b1;
    logic       pass_run = 1'b1;
    logic       res_vld = 1'b0;
    logic [1:0] res_tag = 2'b00;
    logic [1:0] probe_tag = 2'b00;
    logic [4:0] gwr;
    logic [5:0] gwr_wide;
    logic       tag_ignore;
    logic [6:0] probe_move;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int exp_w = 0;

    always #5 clk = ~clk;

    bfp_pass_seq #(.DRAIN(DRAIN)) u0 (
        .clk(clk), .rst(rst), .sof_n(sof_n), .pass_run(pass_run),
        .res_vld(res_vld), .res_tag(res_tag), .probe_tag(probe_tag),
        .gwr(gwr), .gwr_wide(gwr_wide), .tag_ignore(tag_ignore),
        .probe_move(probe_move)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_state();
        chk("R4 R5 gwr code", int'(gwr), exp_w & 31);
        chk("R9 wide value", int'($signed(gwr_wide)), exp_w);
        for (int t = 0; t < 4; t++) begin
            probe_tag = 2'(t);
            #1;
            chk("R10 probe move", int'($signed(probe_move)), exp_w + t - 1);
        end
    endtask

    // One pass: NB inputs, last on pass_run low, low window of low_len cycles
    task automatic run_pass(input bit first, input logic [7:0] tags,
                            input logic [3:0] vmask, input int low_len);
        int mn;
        int old;
        mn = 99;
        if (first) exp_w = 0;
        old = exp_w;
        for (int k = 0; k < NB; k++)
            if (vmask[k] && int'(tags[2*k +: 2]) < mn) mn = int'(tags[2*k +: 2]);
        for (int c = 0; c < NB - 1 + low_len; c++) begin
            int r;
            sof_n    = !(first && c == 0);
            pass_run = (c < NB - 1);
            r = c - (DRAIN - 1);
            if (r >= 0 && r < NB) begin
                res_vld = vmask[r];
                res_tag = tags[2*r +: 2];
            end else begin
                res_vld = 1'b0;
                res_tag = 2'b00;
            end
            #1;
            if (first && c == 0)
                chk("R3 ignore at start", int'(tag_ignore), 1);
            if (first && c == 1)
                chk("R2 cleared after start", int'(gwr), 0);
            if (first && c == NB - 1 + DRAIN - 1)
                chk("R3 ignore held to commit", int'(tag_ignore), 1);
            if (c == NB - 1 + DRAIN - 1)
                chk("R4 no early update", int'(gwr), old & 31);
            @(negedge clk);
        end
        sof_n   = 1'b1;
        res_vld = 1'b0;
        if (mn != 99) begin
            exp_w = exp_w + mn - 1;
            if (exp_w < -8) exp_w = -8;
            if (exp_w > 23) exp_w = 23;
        end
        check_state();
        chk("R3 ignore cleared", int'(tag_ignore), 0);
        if (low_len > DRAIN)
            chk("R7 single commit", int'(gwr), exp_w & 31);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset gwr", int'(gwr), 0);
        chk("R1 reset wide", int'(gwr_wide), 0);
        chk("R1 reset ignore", int'(tag_ignore), 1);
        @(negedge clk);

        // R5 R6 R11: sweep of every tag combination over a 4-result pass
        for (int combo = 0; combo < 256; combo++) begin
            logic [3:0] vm;
            vm = 4'hF;
            if (combo % 5 == 4) vm = 4'(combo);
            if (combo % 17 == 3) vm = 4'h0;
            run_pass(combo % 6 == 0, 8'(combo), vm, DRAIN + (combo % 3) * 2);
        end

        // R8: climb to the ceiling, then fall to the floor
        run_pass(1'b1, 8'hFF, 4'hF, DRAIN);
        for (int p = 0; p < 14; p++) run_pass(1'b0, 8'hFF, 4'hF, DRAIN);
        chk("R8 ceiling", int'($signed(gwr_wide)), 23);
        for (int p = 0; p < 40; p++) run_pass(1'b0, 8'h00, 4'hF, DRAIN + 1);
        chk("R8 floor", int'($signed(gwr_wide)), -8);

        // R2: restart from a nonzero register, R11 empty pass
        run_pass(1'b0, 8'hFF, 4'hF, DRAIN);
        run_pass(1'b1, 8'h55, 4'h0, DRAIN + 3);
        chk("R11 empty pass", int'(gwr), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule